// File: doc/BRIEF.md
# Shadowed Multi-Channel PWM Bank

This block is a bank of independent pulse-width generators behind one small register port. Each channel counts input clock cycles over a programmable period. For the first part of that period, set by a programmable first-phase count, the channel drives a chosen level. For the rest of the period it drives the opposite level. Software writes go to a shadow copy of each setting. The counter only ever works from an active copy.

Software moves the shadow copy into the active copy by setting an update-request bit. The transfer then takes place on the edge that closes the current period, so a running waveform changes only between whole periods. A separate run bit launches a stopped channel. The rising edge of that bit restarts the count at zero and applies any pending update at once. To disable a channel, software can program a first-phase count of zero, which holds the pin low.

The register port is single-cycle. Writes are registered on the clock edge, and reads return the shadow values combinationally from the byte offset.

Top module: `pwm_bank`

## Requirements
- R1: There are six channels. Channel n decodes byte offsets n*0x20 + 0x00 (control), n*0x20 + 0x08 (period) and n*0x20 + 0x0C (first-phase count). Reads return the programmed shadow values, and any other offset reads as zero.
- R2: Control bit 0 is the run bit, bit 2 is the update request, bit 5 is the stored continuous-mode flag and bit 8 is the first-phase level. A control read returns these fields in the same positions.
- R3: While a channel runs, written period, count and level values do not alter its output until an update is requested. After the request, they apply from the edge that follows the cycle in which the count equals period minus one.
- R4: A control read shows bit 2 as 1 from the write that requests an update until the transfer takes place, and as 0 afterwards. Writing 0 to bit 2 leaves a pending request in place.
- R5: A control write that sets the run bit while the channel is stopped restarts the count at 0 and applies a pending update on that same edge. The count is 0 in the first cycle after the write. A run-bit write to a running channel does not restart it.
- R6: With count c (0 to period minus one), the output equals the first-phase level while c is below the first-phase count and its inverse otherwise.
- R7: A first-phase count equal to or above the period holds the output at the first-phase level for the whole period.
- R8: A first-phase count of zero holds the output low whatever the level bit is, and so does a period of zero.
- R9: A channel whose run bit is 0 drives low. Clearing the run bit forces the output low from the next cycle.
- R10: Writes to undecoded offsets, including the windows of channel indices 6 and 7, change no register and no output.
- R11: After reset every register reads 0 and every output is low.
- R12: Channels are independent. Configuring or running one channel leaves the other outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, registered on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 6 | One waveform output per channel |

## Verification
The hardest situation to reach from the ports is an update request that arrives in the middle of a running period. Stale settings must then persist through exactly the remaining cycles of that period, and the new ones must appear on the very next count of zero. The bench starts a channel and counts edges from the start write. It lands a new first-phase value and an update request a few cycles into the period. It then compares every cycle across the boundary and reads the pending bit on both sides of it. The same sequence also shows that a run-bit write to a running channel does not restart the count.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // Byte offsets inside one channel window
   localparam int unsigned OFS_CTRL   = 0;
   localparam int unsigned OFS_PERIOD = 8;
   localparam int unsigned OFS_FIRST  = 12;

   // Control word bit positions
   localparam int unsigned BIT_RUN  = 0;
   localparam int unsigned BIT_UPD  = 2;
   localparam int unsigned BIT_CONT = 5;
   localparam int unsigned BIT_LVL  = 8;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_CTRL   = 2'd1,
      SEL_PERIOD = 2'd2,
      SEL_FIRST  = 2'd3
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input int unsigned ofs);
      reg_sel_e s;
      case (ofs)
         OFS_CTRL:   s = SEL_CTRL;
         OFS_PERIOD: s = SEL_PERIOD;
         OFS_FIRST:  s = SEL_FIRST;
         default:    s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
   import pwm_bank_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wrap,
   output logic              run,
   output logic              pend,
   output logic [CNT_W-1:0]  act_period,
   output logic [CNT_W-1:0]  act_first,
   output logic              act_lvl,
   output logic [DATA_W-1:0] rd_data
);

   logic             run_q, pend_q, sh_lvl_q, sh_cont_q, act_lvl_q;
   logic [CNT_W-1:0] sh_per_q, sh_first_q, act_per_q, act_first_q;

   logic             ctrl_wr, set_upd, start, want, load;
   logic             lvl_n, cont_n;
   logic [CNT_W-1:0] per_n, first_n;

   always_comb begin
      ctrl_wr = wr_en && (sel == SEL_CTRL);
      set_upd = ctrl_wr && wdata[BIT_UPD];
      start   = ctrl_wr && wdata[BIT_RUN] && !run_q;
      per_n   = (wr_en && sel == SEL_PERIOD) ? wdata[CNT_W-1:0] : sh_per_q;
      first_n = (wr_en && sel == SEL_FIRST)  ? wdata[CNT_W-1:0] : sh_first_q;
      lvl_n   = ctrl_wr ? wdata[BIT_LVL]  : sh_lvl_q;
      cont_n  = ctrl_wr ? wdata[BIT_CONT] : sh_cont_q;
      want    = pend_q || set_upd;
      // transfer on a launch edge or on the edge that closes a period
      load    = want && (start || wrap);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q       <= 1'b0;
         pend_q      <= 1'b0;
         sh_lvl_q    <= 1'b0;
         sh_cont_q   <= 1'b0;
         sh_per_q    <= '0;
         sh_first_q  <= '0;
         act_per_q   <= '0;
         act_first_q <= '0;
         act_lvl_q   <= 1'b0;
      end else begin
         if (ctrl_wr) run_q <= wdata[BIT_RUN];
         sh_per_q   <= per_n;
         sh_first_q <= first_n;
         sh_lvl_q   <= lvl_n;
         sh_cont_q  <= cont_n;
         pend_q     <= want && !load;
         if (load) begin
            act_per_q   <= per_n;
            act_first_q <= first_n;
            act_lvl_q   <= lvl_n;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (sel)
         SEL_CTRL: begin
            rd_data[BIT_RUN]  = run_q;
            rd_data[BIT_UPD]  = pend_q;
            rd_data[BIT_CONT] = sh_cont_q;
            rd_data[BIT_LVL]  = sh_lvl_q;
         end
         SEL_PERIOD: rd_data = DATA_W'(sh_per_q);
         SEL_FIRST:  rd_data = DATA_W'(sh_first_q);
         default:    rd_data = '0;
      endcase
   end

   assign run        = run_q;
   assign pend       = pend_q;
   assign act_period = act_per_q;
   assign act_first  = act_first_q;
   assign act_lvl    = act_lvl_q;

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
   parameter int CNT_W    = 32,
   parameter bit SYNC_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] first,
   input  logic             lvl,
   output logic             wrap,
   output logic             pwm
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_p1;
   logic             last, level;

   always_comb begin
      cnt_p1 = {1'b0, cnt_q} + (CNT_W+1)'(1);
      last   = cnt_p1 >= {1'b0, period};
      wrap   = run && last;
      if (period == '0 || first == '0) level = 1'b0;
      else if (cnt_q < first)          level = lvl;
      else                             level = !lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run || last)   cnt_q <= '0;
      else                     cnt_q <= cnt_p1[CNT_W-1:0];
   end

   generate
      if (SYNC_OUT) begin : g_sync
         logic pwm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwm_q <= 1'b0;
            else        pwm_q <= run && level;
         end
         assign pwm = pwm_q;
      end else begin : g_comb
         assign pwm = run && level;
      end
   endgenerate

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH    = 6,
   parameter int CNT_W     = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int WIN_BYTES = 32,
   parameter bit SYNC_OUT  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);

   localparam int WIN_LSB = $clog2(WIN_BYTES);
   localparam int IDX_W   = ADDR_W - WIN_LSB;

   generate
      if (NUM_CH < 1 || NUM_CH > (1 << IDX_W)) begin : g_bad_ch
         $error("pwm_bank: NUM_CH does not fit the address space");
      end
      if (CNT_W > DATA_W || DATA_W <= BIT_LVL) begin : g_bad_w
         $error("pwm_bank: data width too narrow");
      end
      if (WIN_BYTES <= OFS_FIRST || (1 << WIN_LSB) != WIN_BYTES) begin : g_bad_win
         $error("pwm_bank: window must be a power of two above the last offset");
      end
   endgenerate

   logic [IDX_W-1:0]   bus_idx;
   logic [WIN_LSB-1:0] bus_ofs;
   reg_sel_e           bus_sel;
   logic [NUM_CH-1:0]  ch_hit, ch_run, ch_pend, ch_wrap;
   logic [DATA_W-1:0]  ch_rd [NUM_CH];

   assign bus_idx = bus_addr[ADDR_W-1:WIN_LSB];
   assign bus_ofs = bus_addr[WIN_LSB-1:0];
   assign bus_sel = decode_ofs(int'(bus_ofs));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [CNT_W-1:0] a_per, a_first;
      logic             a_lvl;

      assign ch_hit[i] = (bus_idx == IDX_W'(i));

      pwm_chan_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (bus_wr && ch_hit[i]),
         .sel       (bus_sel),
         .wdata     (bus_wdata),
         .wrap      (ch_wrap[i]),
         .run       (ch_run[i]),
         .pend      (ch_pend[i]),
         .act_period(a_per),
         .act_first (a_first),
         .act_lvl   (a_lvl),
         .rd_data   (ch_rd[i])
      );

      pwm_chan_core #(.CNT_W(CNT_W), .SYNC_OUT(SYNC_OUT)) u_core (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (ch_run[i]),
         .period(a_per),
         .first (a_first),
         .lvl   (a_lvl),
         .wrap  (ch_wrap[i]),
         .pwm   (pwm_out[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_hit[i]) bus_rdata = ch_rd[i];
      end
   end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
   parameter int NUM_CH    = 6,
   parameter int ADDR_W    = 8,
   parameter int WIN_BYTES = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [NUM_CH-1:0] pwm_out,
   input logic [NUM_CH-1:0] ch_run,
   input logic [NUM_CH-1:0] ch_pend,
   input logic [NUM_CH-1:0] ch_wrap
);

   localparam int WIN_LSB = $clog2(WIN_BYTES);

   logic mapped;
   always_comb begin
      mapped = (int'(bus_addr[ADDR_W-1:WIN_LSB]) < NUM_CH) &&
               (bus_addr[WIN_LSB-1:0] == 0 || bus_addr[WIN_LSB-1:0] == 8 ||
                bus_addr[WIN_LSB-1:0] == 12);
   end

   // R10
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !mapped) |=> $stable(ch_run));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      // R9
      stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_run[i] |-> !pwm_out[i]);
      // R4
      pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_pend[i] && ch_wrap[i]) |=> !ch_pend[i]);
      // R5
      start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_run[i]) |-> !ch_pend[i]);
      // R3
      boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(ch_pend[i]) |-> ($past(ch_wrap[i]) || $rose(ch_run[i])));
   end

endmodule

bind pwm_bank pwm_bank_chk #(
   .NUM_CH   (NUM_CH),
   .ADDR_W   (ADDR_W),
   .WIN_BYTES(WIN_BYTES)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_addr(bus_addr),
   .bus_wr  (bus_wr),
   .pwm_out (pwm_out),
   .ch_run  (ch_run),
   .ch_pend (ch_pend),
   .ch_wrap (ch_wrap)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;

   localparam int CLK_NS = 20;
   localparam logic [31:0] C_RUN  = 32'h001;
   localparam logic [31:0] C_UPD  = 32'h004;
   localparam logic [31:0] C_CONT = 32'h020;
   localparam logic [31:0] C_LVL  = 32'h100;

   // stimulus vectors: channel, period, first-phase count, level
   localparam int NVEC = 8;
   localparam int T_CH [NVEC] = '{0, 3, 5, 1, 2, 4, 5, 0};
   localparam int T_P  [NVEC] = '{5, 6, 4, 4, 0, 3, 1, 7};
   localparam int T_D  [NVEC] = '{2, 4, 9, 7, 3, 0, 1, 1};
   localparam int T_F  [NVEC] = '{1, 0, 1, 0, 1, 0, 1, 1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  pwm_out;

   int  n_cmp = 0;
   int  n_bad = 0;
   int  k = 0;
   bit  done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   pwm_bank u_pwm_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pwm_out  (pwm_out)
   );

   function automatic logic exp_lvl(int kk, int p, int d, int f);
      int c;
      if (p == 0 || d == 0) return 1'b0;
      c = kk % p;
      return (c < d) ? logic'(f != 0) : logic'(f == 0);
   endfunction

   function automatic logic [5:0] exp_vec(int ch, int kk, int p, int d, int f);
      logic [5:0] v = '0;
      v[ch] = exp_lvl(kk, p, d, f);
      return v;
   endfunction

   task automatic check_val(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (k=%0d)", req, act, exp, k);
      end
   endtask

   // called at a falling edge; consumes one rising edge
   task automatic wr(logic [7:0] a, logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      k++;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic tick();
      @(negedge clk);
      k++;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      check_val("R11 outputs after reset", 32'(pwm_out), 32'h0);
      for (int c = 0; c < 6; c++) begin
         rd(8'(c*32),      r); check_val("R11 ctrl reset", r, 0);
         rd(8'(c*32 + 8),  r); check_val("R11 period reset", r, 0);
         rd(8'(c*32 + 12), r); check_val("R11 first reset", r, 0);
      end

      // R10 undecoded writes
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'hC0, 32'hFFFF_FFFF);
      wr(8'hE8, 32'h0000_0003);
      wr(8'hEC, 32'h0000_0002);
      wr(8'h10, 32'hFFFF_FFFF);
      tick(); tick();
      check_val("R10 outputs after undecoded writes", 32'(pwm_out), 32'h0);
      for (int c = 0; c < 6; c++) begin
         rd(8'(c*32),      r); check_val("R10 ctrl untouched", r, 0);
         rd(8'(c*32 + 8),  r); check_val("R10 period untouched", r, 0);
         rd(8'(c*32 + 12), r); check_val("R10 first untouched", r, 0);
      end
      rd(8'hC0, r); check_val("R1 unmapped read", r, 0);
      rd(8'h04, r); check_val("R1 unmapped read", r, 0);

      // R1 / R2 readback of shadow values
      wr(8'h48, 32'hDEAD_BEEF);
      rd(8'h48, r); check_val("R1 period readback", r, 32'hDEAD_BEEF);
      wr(8'hAC, 32'h1234_5678);
      rd(8'hAC, r); check_val("R1 first readback ch5", r, 32'h1234_5678);
      wr(8'h60, C_LVL | C_CONT);
      rd(8'h60, r); check_val("R2 ctrl field positions", r, 32'h120);

      // R4 zero in update bit keeps a pending request
      wr(8'h20, C_UPD);
      rd(8'h20, r); check_val("R4 pending set", r, 32'h004);
      wr(8'h20, 32'h0);
      rd(8'h20, r); check_val("R4 pending kept", r, 32'h004);

      // vector table: R5 R6 R7 R8 R9 R12
      for (int t = 0; t < NVEC; t++) begin
         int ch, p, d, n;
         logic [31:0] fb;
         ch = T_CH[t]; p = T_P[t]; d = T_D[t];
         fb = (T_F[t] != 0) ? C_LVL : 32'h0;
         wr(8'(ch*32 + 8),  32'(p));
         wr(8'(ch*32 + 12), 32'(d));
         wr(8'(ch*32), fb | C_CONT | C_UPD);
         rd(8'(ch*32), r); check_val("R4 pending while stopped", {31'b0, r[2]}, 1);
         wr(8'(ch*32), fb | C_CONT | C_RUN);
         k = 0;
         rd(8'(ch*32), r); check_val("R5 update applied at start", {31'b0, r[2]}, 0);
         n = (p < 2) ? 6 : 2*p + 2;
         for (int j = 0; j < n; j++) begin
            check_val("R6 R7 R8 R12 waveform", 32'(pwm_out),
                      32'(exp_vec(ch, k, p, d, T_F[t])));
            tick();
         end
         wr(8'(ch*32), fb | C_CONT);
         check_val("R9 stop forces low", 32'(pwm_out), 32'h0);
      end

      // R3 mid-period update on a running channel
      wr(8'h28, 32'd8);
      wr(8'h2C, 32'd3);
      wr(8'h20, C_LVL | C_CONT | C_UPD);
      wr(8'h20, C_LVL | C_CONT | C_RUN);
      k = 0;
      check_val("R5 first cycle after start", 32'(pwm_out), 32'(exp_vec(1, 0, 8, 3, 1)));
      tick();
      check_val("R6 running", 32'(pwm_out), 32'(exp_vec(1, k, 8, 3, 1)));
      tick();
      check_val("R6 running", 32'(pwm_out), 32'(exp_vec(1, k, 8, 3, 1)));
      wr(8'h2C, 32'd6);
      check_val("R3 old count before request", 32'(pwm_out), 32'(exp_vec(1, k, 8, 3, 1)));
      wr(8'h20, C_LVL | C_CONT | C_RUN | C_UPD);
      check_val("R3 R5 no restart, old count", 32'(pwm_out), 32'(exp_vec(1, k, 8, 3, 1)));
      rd(8'h20, r); check_val("R4 pending while running", {31'b0, r[2]}, 1);
      while (k < 7) begin
         tick();
         check_val("R3 old count to period end", 32'(pwm_out), 32'(exp_vec(1, k, 8, 3, 1)));
      end
      tick();
      rd(8'h20, r); check_val("R4 pending cleared at boundary", {31'b0, r[2]}, 0);
      while (k < 16) begin
         check_val("R3 new count after boundary", 32'(pwm_out), 32'(exp_vec(1, k, 8, 6, 1)));
         tick();
      end
      wr(8'h20, C_LVL | C_CONT);
      check_val("R9 final stop", 32'(pwm_out), 32'h0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule